// File: doc/BRIEF.md
# Power-Fail Gated SRAM Bank Controller

This block is the digital core of a supervisor that keeps battery-backed static RAM safe across supply loss. It receives a synchronized supply-valid flag and a battery-low flag from external comparators, an active-low chip enable from the host and a one-bit bank select. It produces two conditioned active-low chip enables, one per RAM bank, an active-low system reset and a latched active-low battery warning. While the supply is good and the recovery hold has ended, the host chip enable goes to exactly one bank. At any other time both banks are write-protected.

Two state machines, both clocked by a free-running clock, do the work. The power sequencer has three states. PS_DOWN is the state with no supply. PS_RECOVER is the timed hold after the supply returns. PS_UP is normal operation. Its transitions are: supply-return (DOWN to RECOVER), hold-done (RECOVER to UP, which also samples the battery flag), and supply-drop (RECOVER or UP to DOWN). The reset generator has three states. RS_HOLD keeps reset asserted. RS_TIME counts the release timeout. RS_RUN releases reset. Its transitions are: start-timer (HOLD to TIME, once the supply is good and no long press is present), timeout (TIME to RUN), and abort (TIME or RUN to HOLD on a supply drop or a long press). A pushbutton input counts as pressed only once it has been held low for a minimum number of cycles.

Top module: `sram_pwr_guard`

## Requirements
- R1: While `cen_in` is 1, both bits of `cen_out_n` are 1, for either value of `bank_sel`.
- R2: In PS_UP with the supply good and `cen_in` 0, `bank_sel`=0 drives only `cen_out_n[0]` low and `bank_sel`=1 drives only `cen_out_n[1]` low. At most one bit of `cen_out_n` is ever low.
- R3: When `supply_ok` is 0, both bits of `cen_out_n` are 1 in that same cycle, whatever `cen_in` and `bank_sel` are.
- R4: After the first rising clock edge that samples `supply_ok`=1, both chip enables stay 1 for exactly REC_CYC edges and are decoded from the edge after that. A supply drop during the hold restarts the count.
- R5: `sys_rst_n` is 0 in any cycle in which `supply_ok` is 0.
- R6: `sys_rst_n` goes to 1 exactly RST_CYC edges after the first edge that samples `supply_ok`=1. A supply drop during the count restarts it.
- R7: `batt_warn_n` resets to 1 (battery OK). It loads the inverse of `batt_low` only on the edge that ends the recovery hold (0 means the battery is low), and it holds that value through supply drops until the next hold ends.
- R8: `pb_n` held at 0 for fewer than PB_MIN consecutive edges has no effect on `sys_rst_n`. Once it has been held for PB_MIN edges, reset is asserted on the next edge.
- R9: After a recognised press is released, `sys_rst_n` returns to 1 exactly RST_CYC+1 edges after the first edge that samples `pb_n`=1.
- R10: While `arst_n` is 0, the outputs are: chip enables 1, reset 0, warning 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| arst_n | input | 1 | Asynchronous initialisation, active low |
| supply_ok | input | 1 | Synchronized supply-valid flag from the comparator |
| batt_low | input | 1 | Battery-low flag from the comparator, 1 = low |
| pb_n | input | 1 | Synchronized pushbutton, active low |
| cen_in | input | 1 | Host chip enable, active low |
| bank_sel | input | 1 | Bank select: 0 = bank 0, 1 = bank 1 |
| cen_out_n | output | 2 | Conditioned chip enables, bit b for bank b, active low |
| sys_rst_n | output | 1 | System reset, active low |
| batt_warn_n | output | 1 | Latched battery warning, 0 = battery low |

## Verification
Bank decoding and power-fail protection can act in the same cycle. The bench therefore removes `supply_ok` in the middle of a cycle while a bank is actively selected. The chip enables and the reset must both be inactive or asserted within that cycle, and the warning must keep its value. The same overlap is also forced in the recovery window: the supply drops partway through the hold and must restart both the recovery count and the reset count. The restarted count is then judged to the exact edge. The pushbutton and the reset timeout meet in the same way: the bench makes a long press while reset is released, and a short press that must not disturb either output.

// File: rtl/sram_guard_pkg.sv
package sram_guard_pkg;
    typedef enum logic [1:0] {
        PS_DOWN    = 2'd0,
        PS_RECOVER = 2'd1,
        PS_UP      = 2'd2
    } pwr_state_e;

    typedef enum logic [1:0] {
        RS_HOLD = 2'd0,
        RS_TIME = 2'd1,
        RS_RUN  = 2'd2
    } rst_state_e;
endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import sram_guard_pkg::*;
#(
    parameter int REC_CYC = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic batt_low,
    output logic write_prot,
    output logic batt_warn_n
);
    localparam int CW = $clog2(REC_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(REC_CYC - 1);

    pwr_state_e      state, nxt;
    logic [CW-1:0]   cnt;

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            PS_DOWN:    if (supply_ok) nxt = PS_RECOVER;
            PS_RECOVER: if (!supply_ok) nxt = PS_DOWN;
                        else if (cnt == LAST) nxt = PS_UP;
            PS_UP:      if (!supply_ok) nxt = PS_DOWN;
            default:    nxt = PS_DOWN;
        endcase
    end

    // state register, hold counter and warning latch
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state       <= PS_DOWN;
            cnt         <= '0;
            batt_warn_n <= 1'b1;
        end else begin
            state <= nxt;
            cnt   <= (state == PS_RECOVER && nxt == PS_RECOVER) ? cnt + 1'b1 : '0;
            if (state == PS_RECOVER && nxt == PS_UP)
                batt_warn_n <= ~batt_low;
        end
    end

    // outputs
    always_comb begin
        write_prot = !supply_ok || (state != PS_UP);
    end

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!arst_n)
        cnt <= LAST);
    p_up_after_hold_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (state == PS_UP && $past(state) == PS_RECOVER) |-> $past(cnt) == LAST);
    p_warn_hold_r7: assert property (@(posedge clk) disable iff (!arst_n)
        !($past(state) == PS_RECOVER && state == PS_UP) |-> $stable(batt_warn_n));
endmodule

// File: rtl/rst_gen_fsm.sv
module rst_gen_fsm
    import sram_guard_pkg::*;
#(
    parameter int RST_CYC = 8,
    parameter int PB_MIN  = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic pb_n,
    output logic sys_rst_n
);
    localparam int CW = $clog2(RST_CYC + 1);
    localparam int PW = $clog2(PB_MIN + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);
    localparam logic [PW-1:0] PB_TOP = PW'(PB_MIN);

    rst_state_e     state, nxt;
    logic [CW-1:0]  cnt;
    logic [PW-1:0]  pb_cnt;
    logic           pb_held;

    assign pb_held = (pb_cnt == PB_TOP);

    // press qualifier: saturating run length of a low button
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     pb_cnt <= '0;
        else if (pb_n)   pb_cnt <= '0;
        else if (!pb_held) pb_cnt <= pb_cnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RS_HOLD: if (supply_ok && !pb_held) nxt = RS_TIME;
            RS_TIME: if (!supply_ok || pb_held) nxt = RS_HOLD;
                     else if (cnt == LAST) nxt = RS_RUN;
            RS_RUN:  if (!supply_ok || pb_held) nxt = RS_HOLD;
            default: nxt = RS_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= RS_HOLD;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == RS_TIME && nxt == RS_TIME) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        sys_rst_n = supply_ok && (state == RS_RUN);
    end

    p_run_after_count_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (state == RS_RUN && $past(state) == RS_TIME) |-> $past(cnt) == LAST);
    p_press_qualified_r8: assert property (@(posedge clk) disable iff (!arst_n)
        pb_held |-> $past(!pb_n));
endmodule

// File: rtl/bank_decode.sv
module bank_decode #(
    parameter int BANKS = 2,
    localparam int SELW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic            write_prot,
    input  logic            cen_in,
    input  logic [SELW-1:0] bank_sel,
    output logic [BANKS-1:0] cen_n
);
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        assign cen_n[g] = write_prot | cen_in | (bank_sel != SELW'(g));
    end
endmodule

// File: rtl/sram_pwr_guard.sv
module sram_pwr_guard #(
    parameter int REC_CYC = 8_000_000,
    parameter int RST_CYC = 8_000_000,
    parameter int PB_MIN  = 200
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       supply_ok,
    input  logic       batt_low,
    input  logic       pb_n,
    input  logic       cen_in,
    input  logic       bank_sel,
    output logic [1:0] cen_out_n,
    output logic       sys_rst_n,
    output logic       batt_warn_n
);
    logic write_prot;

    pwr_seq_fsm #(.REC_CYC(REC_CYC)) u_pwr (
        .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .batt_low(batt_low),
        .write_prot(write_prot), .batt_warn_n(batt_warn_n)
    );

    rst_gen_fsm #(.RST_CYC(RST_CYC), .PB_MIN(PB_MIN)) u_rst (
        .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .pb_n(pb_n),
        .sys_rst_n(sys_rst_n)
    );

    bank_decode #(.BANKS(2)) u_dec (
        .write_prot(write_prot), .cen_in(cen_in), .bank_sel(bank_sel),
        .cen_n(cen_out_n)
    );

    p_idle_r1: assert property (@(posedge clk) disable iff (!arst_n)
        cen_in |-> (cen_out_n == 2'b11));
    p_onehot_r2: assert property (@(posedge clk) disable iff (!arst_n)
        $onehot0(~cen_out_n));
    p_select_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (!write_prot && !cen_in) |-> (cen_out_n[bank_sel] == 1'b0));
    p_drop_prot_r3: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |-> (cen_out_n == 2'b11));
    p_drop_rst_r5: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |-> !sys_rst_n);
endmodule

// File: tb/sram_pwr_guard_bench.sv
`timescale 1ns/1ps
module sram_pwr_guard_bench;
    localparam int REC = 20;
    localparam int RST = 30;
    localparam int PBM = 4;

    logic clk = 1'b0;
    logic arst_n, supply_ok, batt_low, pb_n, cen_in, bank_sel;
    logic [1:0] cen_out_n;
    logic sys_rst_n, batt_warn_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    string      q_req[$];
    logic [3:0] q_exp[$];
    event       smp_ev;

    always #2.5 clk = ~clk;

    sram_pwr_guard #(.REC_CYC(REC), .RST_CYC(RST), .PB_MIN(PBM)) u_sram_pwr_guard (
        .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .batt_low(batt_low),
        .pb_n(pb_n), .cen_in(cen_in), .bank_sel(bank_sel),
        .cen_out_n(cen_out_n), .sys_rst_n(sys_rst_n), .batt_warn_n(batt_warn_n)
    );

    // monitor: observed word {cen1_n, cen0_n, rst_n, warn_n}
    initial begin
        forever begin
            @(smp_ev);
            while (q_exp.size() > 0) begin
                logic [3:0] e;
                logic [3:0] obs;
                string r;
                e   = q_exp.pop_front();
                r   = q_req.pop_front();
                obs = {cen_out_n[1], cen_out_n[0], sys_rst_n, batt_warn_n};
                compared++;
                if (obs !== e) begin
                    mismatched++;
                    $display("FAIL %s: actual %b expected %b", r, obs, e);
                end
            end
        end
    end

    // driver side: push an expected item, then let the monitor sample
    task automatic chk(input string req, input logic [3:0] e);
        q_req.push_back(req);
        q_exp.push_back(e);
        #0.5;
        -> smp_ev;
        #0.5;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        arst_n = 0; supply_ok = 0; batt_low = 1; pb_n = 1; cen_in = 0; bank_sel = 0;
        step(3);
        chk("R10 reset state", 4'b1101);
        arst_n = 1;
        step(2);
        chk("R3 no supply", 4'b1101);

        // power-up, battery low, bank 0 requested throughout
        supply_ok = 1;
        step(REC);
        chk("R4 hold last protected edge", 4'b1101);
        step(1);
        chk("R4 R7 hold done, bank0, warn low", 4'b1000);
        step(RST - REC - 1);
        chk("R6 reset one edge early", 4'b1000);
        step(1);
        chk("R6 reset released", 4'b1010);

        // decode table
        cen_in = 1; bank_sel = 0; #1; chk("R1 idle sel0", 4'b1110);
        bank_sel = 1;             #1; chk("R1 idle sel1", 4'b1110);
        cen_in = 0; bank_sel = 0; #1; chk("R2 sel0 bank0", 4'b1010);
        bank_sel = 1;             #1; chk("R2 sel1 bank1", 4'b0110);
        batt_low = 0;             #1; chk("R7 warn not resampled", 4'b0110);

        // glitch during active access
        bank_sel = 0; #1;
        supply_ok = 0; #1;
        chk("R3 R5 drop mid-access", 4'b1100);
        step(1);
        supply_ok = 1;
        step(10);
        chk("R4 partial hold", 4'b1100);
        supply_ok = 0; #1;
        chk("R3 R5 drop during hold", 4'b1100);
        step(1);
        supply_ok = 1;
        step(REC);
        chk("R4 restarted hold still protected", 4'b1100);
        step(1);
        chk("R4 R7 restarted hold done, warn ok", 4'b1001);
        step(RST - REC - 1);
        chk("R6 restarted reset early", 4'b1001);
        step(1);
        chk("R6 restarted reset released", 4'b1011);

        // short press ignored
        pb_n = 0;
        step(PBM - 1);
        pb_n = 1;
        chk("R8 short press", 4'b1011);
        step(3);
        chk("R8 short press after", 4'b1011);

        // long press
        pb_n = 0;
        step(PBM);
        chk("R8 press qualified, not yet", 4'b1011);
        step(1);
        chk("R8 long press resets", 4'b1001);
        step(5);
        pb_n = 1;
        step(1);
        chk("R9 release edge", 4'b1001);
        step(RST);
        chk("R9 timeout one edge early", 4'b1001);
        step(1);
        chk("R9 timeout done", 4'b1011);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule